// File: doc/BRIEF.md
# Transmit Modulation Control

This block sits between a serial transmit bit and the two control words of a fractional-N synthesizer transmitter. On every clock it turns the current data bit and a set of stored configuration fields into a 15-bit fractional divide word for a downstream sigma-delta modulator and a 7-bit code for the power-amplifier DAC. The clock stands in for the phase-detector reference clock, so one frequency step of the fractional word is the reference frequency divided by 2^15, and a deviation step is eight of those.

A 2-bit scheme field picks one of four keying modes. The two frequency modes move the divide word above or below a centre value. The two amplitude modes pick between two programmed PA codes, or between one code and off. In the Gaussian frequency mode the block also produces a bit clock for the data source and latches the data once per bit. Pulse shaping is done further down the chain, so here the word only steps by the programmed deviation magnitude.

Top module: `tx_mod_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `frac_word`, `pa_dac` and `tx_bit_clk` to zero. `scheme_sel` encodes the mode as 00 frequency keying (FSK), 01 Gaussian frequency keying (GFSK), 10 amplitude keying (ASK) and 11 on-off keying (OOK).
- R2: The centre word is `{frac_base, 3'b000}` plus `freq_trim` sign-extended from 11 bits, taken modulo 2^15.
- R3: In FSK the word is the centre plus `dev_code`×8 for a 1 bit and the centre minus `dev_code`×8 for a 0 bit. A `dev_code` of 0 leaves the word at the centre.
- R4: When `invert_data` is 1, every mode uses the inverse of `tx_data`.
- R5: In ASK a 0 bit drives `zero_level` onto `pa_dac` and a 1 bit drives `pa_level`. The word stays at the centre.
- R6: In OOK a 1 bit drives `pa_level` and a 0 bit drives 0 (range bits 6:5 = 00, PA off). The word stays at the centre.
- R7: When `pa_enable` is 0, `pa_dac` is 0 in every mode.
- R8: Both outputs are registered. They reflect the inputs sampled at a clock edge and change only after that edge.
- R9: In GFSK, `tx_bit_clk` has a period of F×I clocks. F is `div_factor`, with 0 treated as 1. I is 16, 32, 64 or 128 for `idx_sel` 00, 01, 10 or 11. After GFSK is entered it first goes high F×I/2 edges later. Outside GFSK it is held at 0.
- R10: In GFSK the data bit is captured at the edge where `tx_bit_clk` rises and is held for the whole bit. The word is the centre ± 2^`mod_exp`×8. Before the first capture the word uses a 0 bit.
- R11: In FSK and GFSK, `pa_dac` carries `pa_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| scheme_sel | input | 2 | Keying mode |
| frac_base | input | 12 | Programmed fraction |
| freq_trim | input | 11 | Two's-complement frequency trim |
| dev_code | input | 7 | FSK deviation steps and ASK zero-bit PA code |
| pa_level | input | 7 | PA code for a 1 bit |
| mod_exp | input | 3 | GFSK deviation exponent |
| div_factor | input | 7 | Bit-rate divider factor |
| idx_sel | input | 2 | Bit-rate index counter select |
| invert_data | input | 1 | Invert transmit data |
| pa_enable | input | 1 | PA enable |
| tx_data | input | 1 | Transmit data bit |
| frac_word | output | 15 | Fractional divide word |
| pa_dac | output | 7 | PA DAC code |
| tx_bit_clk | output | 1 | GFSK bit clock |

## Verification
The hardest case to reach is the GFSK bit boundary. The captured bit must change exactly at the bit-clock rising edge and stay put while `tx_data` moves mid-bit. The bench therefore leaves GFSK for one cycle before each GFSK run, so the bit counter restarts from a known zero. It then counts edges to the predicted half-period and flips `tx_data` right after a capture. Running with a divider of 0 and with a larger index confirms both the zero-as-one rule and the index encoding.

// File: rtl/txmod_pkg.sv
package txmod_pkg;
  typedef enum logic [1:0] {
    SCH_FSK  = 2'b00,
    SCH_GFSK = 2'b01,
    SCH_ASK  = 2'b10,
    SCH_OOK  = 2'b11
  } scheme_e;
endpackage

// File: rtl/txmod_bitclk.sv
module txmod_bitclk #(
  parameter int DIVF_W     = 7,
  parameter int CNT_W      = 14,
  parameter int BASE_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DIVF_W-1:0] divf,
  input  logic [1:0]        idx_sel,
  output logic              bclk,
  output logic              rise
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  half;
  logic [DIVF_W-1:0] divf_eff;
  logic              wrap;

  // half period = F * I / 2, with I = 16 << idx_sel
  always_comb begin
    divf_eff = (divf == '0) ? DIVF_W'(1) : divf;
    half     = CNT_W'(divf_eff) << (BASE_SHIFT + int'(idx_sel));
    wrap     = (cnt == half - CNT_W'(1));
    rise     = run && wrap && !bclk;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/txmod_freq.sv
module txmod_freq
  import txmod_pkg::*;
#(
  parameter int FRAC_W = 12,
  parameter int TRIM_W = 11,
  parameter int WORD_W = 15,
  parameter int DEV_W  = 7,
  parameter int MEXP_W = 3
) (
  input  scheme_e           scheme,
  input  logic [FRAC_W-1:0] frac_base,
  input  logic [TRIM_W-1:0] freq_trim,
  input  logic [DEV_W-1:0]  dev_code,
  input  logic [MEXP_W-1:0] mod_exp,
  input  logic              bit_val,
  output logic [WORD_W-1:0] word
);
  localparam int SHIFT = WORD_W - FRAC_W;

  logic [WORD_W-1:0] center;
  logic [WORD_W-1:0] mag;

  always_comb begin
    center = {frac_base, {SHIFT{1'b0}}}
           + {{(WORD_W-TRIM_W){freq_trim[TRIM_W-1]}}, freq_trim};
    unique case (scheme)
      SCH_FSK:  mag = WORD_W'(dev_code) << SHIFT;
      SCH_GFSK: mag = WORD_W'(1) << (int'(mod_exp) + SHIFT);
      default:  mag = '0;
    endcase
    word = bit_val ? center + mag : center - mag;
  end
endmodule

// File: rtl/txmod_pa.sv
module txmod_pa
  import txmod_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  scheme_e          scheme,
  input  logic             bit_val,
  input  logic             pa_enable,
  input  logic [LVL_W-1:0] pa_level,
  input  logic [LVL_W-1:0] zero_level,
  output logic [LVL_W-1:0] code
);
  always_comb begin
    unique case (scheme)
      SCH_ASK: code = bit_val ? pa_level : zero_level;
      SCH_OOK: code = bit_val ? pa_level : '0;
      default: code = pa_level;
    endcase
    if (!pa_enable) code = '0;
  end
endmodule

// File: rtl/tx_mod_ctrl.sv
module tx_mod_ctrl
  import txmod_pkg::*;
#(
  parameter int FRAC_W = 12,
  parameter int TRIM_W = 11,
  parameter int WORD_W = 15,
  parameter int LVL_W  = 7,
  parameter int MEXP_W = 3,
  parameter int DIVF_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        scheme_sel,
  input  logic [FRAC_W-1:0] frac_base,
  input  logic [TRIM_W-1:0] freq_trim,
  input  logic [LVL_W-1:0]  dev_code,
  input  logic [LVL_W-1:0]  pa_level,
  input  logic [MEXP_W-1:0] mod_exp,
  input  logic [DIVF_W-1:0] div_factor,
  input  logic [1:0]        idx_sel,
  input  logic              invert_data,
  input  logic              pa_enable,
  input  logic              tx_data,
  output logic [WORD_W-1:0] frac_word,
  output logic [LVL_W-1:0]  pa_dac,
  output logic              tx_bit_clk
);
  // counter must hold F_max * 128 / 2
  localparam int CNT_W = DIVF_W + 7;

  scheme_e           scheme;
  logic              gfsk;
  logic              data_eff;
  logic              gfsk_bit;
  logic              bit_rise;
  logic              bit_val;
  logic [WORD_W-1:0] word_d;
  logic [LVL_W-1:0]  code_d;

  always_comb begin
    scheme   = scheme_e'(scheme_sel);
    gfsk     = (scheme == SCH_GFSK);
    data_eff = tx_data ^ invert_data;
    bit_val  = gfsk ? (bit_rise ? data_eff : gfsk_bit) : data_eff;
  end

  txmod_bitclk #(.DIVF_W(DIVF_W), .CNT_W(CNT_W), .BASE_SHIFT(3)) u_bitclk (
    .clk     (clk),
    .rst     (rst),
    .run     (gfsk),
    .divf    (div_factor),
    .idx_sel (idx_sel),
    .bclk    (tx_bit_clk),
    .rise    (bit_rise)
  );

  txmod_freq #(.FRAC_W(FRAC_W), .TRIM_W(TRIM_W), .WORD_W(WORD_W),
               .DEV_W(LVL_W), .MEXP_W(MEXP_W)) u_freq (
    .scheme    (scheme),
    .frac_base (frac_base),
    .freq_trim (freq_trim),
    .dev_code  (dev_code),
    .mod_exp   (mod_exp),
    .bit_val   (bit_val),
    .word      (word_d)
  );

  txmod_pa #(.LVL_W(LVL_W)) u_pa (
    .scheme     (scheme),
    .bit_val    (bit_val),
    .pa_enable  (pa_enable),
    .pa_level   (pa_level),
    .zero_level (dev_code),
    .code       (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_word <= '0;
      pa_dac    <= '0;
      gfsk_bit  <= 1'b0;
    end else begin
      frac_word <= word_d;
      pa_dac    <= code_d;
      gfsk_bit  <= gfsk ? bit_val : 1'b0;
    end
  end
endmodule

// File: rtl/txmod_chk.sv
module txmod_chk #(
  parameter int LVL_W  = 7,
  parameter int WORD_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        scheme_sel,
  input logic [LVL_W-1:0]  dev_code,
  input logic [LVL_W-1:0]  pa_level,
  input logic              invert_data,
  input logic              pa_enable,
  input logic              tx_data,
  input logic [WORD_W-1:0] frac_word,
  input logic [LVL_W-1:0]  pa_dac,
  input logic              tx_bit_clk
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (frac_word == '0 && pa_dac == '0 && !tx_bit_clk));

  a_r7_pa_forced_off: assert property (@(posedge clk) disable iff (rst)
    !pa_enable |=> pa_dac == '0);

  a_r9_bitclk_idle: assert property (@(posedge clk) disable iff (rst)
    scheme_sel != 2'b01 |=> !tx_bit_clk);

  a_r6_ook_zero_off: assert property (@(posedge clk) disable iff (rst)
    (scheme_sel == 2'b11 && !(tx_data ^ invert_data)) |=> pa_dac == '0);

  a_r5_ask_one_level: assert property (@(posedge clk) disable iff (rst)
    (scheme_sel == 2'b10 && pa_enable && (tx_data ^ invert_data))
      |=> pa_dac == $past(pa_level));

  a_r5_ask_zero_level: assert property (@(posedge clk) disable iff (rst)
    (scheme_sel == 2'b10 && pa_enable && !(tx_data ^ invert_data))
      |=> pa_dac == $past(dev_code));
endmodule

bind tx_mod_ctrl txmod_chk #(.LVL_W(LVL_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_tx_mod_ctrl.sv
module test_tx_mod_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  scheme_sel = 2'b01;
  logic [11:0] frac_base = 12'h123;
  logic [10:0] freq_trim = 11'h055;
  logic [6:0]  dev_code = 7'h11;
  logic [6:0]  pa_level = 7'h22;
  logic [2:0]  mod_exp = 3'd2;
  logic [6:0]  div_factor = 7'd1;
  logic [1:0]  idx_sel = 2'b00;
  logic        invert_data = 1'b0;
  logic        pa_enable = 1'b1;
  logic        tx_data = 1'b1;
  logic [14:0] frac_word;
  logic [6:0]  pa_dac;
  logic        tx_bit_clk;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tx_mod_ctrl i_tx_mod_ctrl (
    .clk(clk), .rst(rst), .scheme_sel(scheme_sel), .frac_base(frac_base),
    .freq_trim(freq_trim), .dev_code(dev_code), .pa_level(pa_level),
    .mod_exp(mod_exp), .div_factor(div_factor), .idx_sel(idx_sel),
    .invert_data(invert_data), .pa_enable(pa_enable), .tx_data(tx_data),
    .frac_word(frac_word), .pa_dac(pa_dac), .tx_bit_clk(tx_bit_clk)
  );

  // {scheme, base, trim, dev, pa, inv, en, data, exp_frac, exp_pa}
  localparam logic [63:0] VEC [12] = '{
    {2'b00, 12'h100, 11'h000, 7'h05, 7'h55, 1'b0, 1'b1, 1'b1, 15'h0828, 7'h55},
    {2'b00, 12'h100, 11'h000, 7'h05, 7'h55, 1'b0, 1'b1, 1'b0, 15'h07D8, 7'h55},
    {2'b00, 12'h100, 11'h000, 7'h05, 7'h55, 1'b1, 1'b1, 1'b1, 15'h07D8, 7'h55},
    {2'b00, 12'h100, 11'h000, 7'h00, 7'h55, 1'b0, 1'b1, 1'b1, 15'h0800, 7'h55},
    {2'b00, 12'h100, 11'h7FF, 7'h02, 7'h55, 1'b0, 1'b1, 1'b1, 15'h080F, 7'h55},
    {2'b00, 12'hFFF, 11'h3FF, 7'h01, 7'h55, 1'b0, 1'b1, 1'b1, 15'h03FF, 7'h55},
    {2'b10, 12'h100, 11'h000, 7'h23, 7'h7F, 1'b0, 1'b1, 1'b0, 15'h0800, 7'h23},
    {2'b10, 12'h100, 11'h000, 7'h23, 7'h7F, 1'b0, 1'b1, 1'b1, 15'h0800, 7'h7F},
    {2'b11, 12'h100, 11'h000, 7'h23, 7'h41, 1'b0, 1'b1, 1'b1, 15'h0800, 7'h41},
    {2'b11, 12'h100, 11'h000, 7'h23, 7'h41, 1'b0, 1'b1, 1'b0, 15'h0800, 7'h00},
    {2'b11, 12'h100, 11'h000, 7'h23, 7'h41, 1'b1, 1'b1, 1'b0, 15'h0800, 7'h41},
    {2'b10, 12'h100, 11'h000, 7'h23, 7'h7F, 1'b0, 1'b0, 1'b1, 15'h0800, 7'h00}
  };
  localparam string TAG [12] = '{"R3", "R3", "R4", "R3", "R2", "R2",
                                 "R5", "R5", "R6", "R6", "R4", "R7"};

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    step(2);
    check("R1", "frac", int'(frac_word), 0);
    check("R1", "pa", int'(pa_dac), 0);
    check("R1", "bitclk", int'(tx_bit_clk), 0);
    rst = 1'b0;

    // vector table: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < 12; i++) begin
      logic [63:0] v;
      v = VEC[i];
      scheme_sel  = v[63:62];
      frac_base   = v[61:50];
      freq_trim   = v[49:39];
      dev_code    = v[38:32];
      pa_level    = v[31:25];
      invert_data = v[24];
      pa_enable   = v[23];
      tx_data     = v[22];
      step(1);
      check(TAG[i], "frac", int'(frac_word), int'(v[21:7]));
      check(TAG[i], "pa", int'(pa_dac), int'(v[6:0]));
    end

    // R8: output changes only after the edge
    scheme_sel = 2'b00; frac_base = 12'h100; freq_trim = '0; dev_code = 7'd5;
    pa_level = 7'h55; invert_data = 1'b0; pa_enable = 1'b1; tx_data = 1'b0;
    step(1);
    tx_data = 1'b1;
    #1;
    check("R8", "frac before edge", int'(frac_word), 'h07D8);
    step(1);
    check("R8", "frac after edge", int'(frac_word), 'h0828);

    // GFSK, F=1, I=16: half period 8
    mod_exp = 3'd2; div_factor = 7'd1; idx_sel = 2'b00;
    scheme_sel = 2'b01; tx_data = 1'b1;
    step(7);
    check("R9", "bitclk low before half", int'(tx_bit_clk), 0);
    check("R10", "frac before capture", int'(frac_word), 'h07E0);
    check("R11", "gfsk pa", int'(pa_dac), 'h55);
    step(1);
    check("R9", "bitclk first rise", int'(tx_bit_clk), 1);
    check("R10", "frac captured one", int'(frac_word), 'h0820);
    tx_data = 1'b0;
    step(1);
    check("R10", "mid-bit data ignored", int'(frac_word), 'h0820);
    step(6);
    check("R9", "bitclk still high", int'(tx_bit_clk), 1);
    step(1);
    check("R9", "bitclk falls", int'(tx_bit_clk), 0);
    check("R10", "frac held to bit end", int'(frac_word), 'h0820);
    step(8);
    check("R9", "bitclk second rise", int'(tx_bit_clk), 1);
    check("R10", "frac captured zero", int'(frac_word), 'h07E0);

    // leave GFSK: clock held low
    scheme_sel = 2'b00;
    step(1);
    check("R9", "bitclk idle outside gfsk", int'(tx_bit_clk), 0);

    // F=3, I=32: half period 48
    div_factor = 7'd3; idx_sel = 2'b01; scheme_sel = 2'b01; tx_data = 1'b1;
    step(47);
    check("R9", "idx 32 low", int'(tx_bit_clk), 0);
    step(1);
    check("R9", "idx 32 rise", int'(tx_bit_clk), 1);

    // F=0 acts as 1, largest exponent
    scheme_sel = 2'b00;
    step(1);
    div_factor = 7'd0; idx_sel = 2'b00; mod_exp = 3'd7; scheme_sel = 2'b01;
    step(7);
    check("R9", "div0 low", int'(tx_bit_clk), 0);
    step(1);
    check("R9", "div0 rise", int'(tx_bit_clk), 1);
    check("R10", "exp 7 offset", int'(frac_word), 'h0C00);

    // R1: reset mid-run
    rst = 1'b1;
    step(1);
    check("R1", "reset frac", int'(frac_word), 0);
    check("R1", "reset bitclk", int'(tx_bit_clk), 0);
    rst = 1'b0;

    finish_run();
  end
endmodule